// File: doc/BRIEF.md
# UART Interrupt Generation Unit

This block merges the status events of a serial port into a single interrupt line. The datapath supplies one-cycle event pulses: a character was received, a character was sent, the transmit shift register became empty, a break was detected, and a FIFO level condition occurred on either side. Each event has its own enable bit. Every enabled event becomes a one-cycle pulse on `irq`.

The receive interrupt has two modes. In immediate mode each received character raises the interrupt on the next cycle. In deferred mode the interrupt waits until the line has been quiet for four character times plus four bit times. A counter of bit-time ticks measures that wait. Each new character restarts the wait, and clearing the receive interrupt enable or the receiver enable cancels it.

The deferral is a three-state machine:
- `DLY_IDLE`: no wait is pending.
- `DLY_WAIT`: the tick counter is running.
- `DLY_FIRE`: a one-cycle state that sends the deferred interrupt.

Its transitions:
- `DLY_IDLE`→`DLY_WAIT` and `DLY_FIRE`→`DLY_WAIT` (arm): a qualified character arrives while deferral is on.
- `DLY_WAIT`→`DLY_WAIT` (reload): any received character arrives.
- `DLY_WAIT`→`DLY_IDLE` (cancel): an enable drops.
- `DLY_WAIT`→`DLY_FIRE` (expire): the terminal tick arrives.
- `DLY_FIRE`→`DLY_IDLE` (done).

The output stage is a two-state machine, `IRQ_QUIET` and `IRQ_PULSE`. In any cycle where at least one qualified source is active, it enters `IRQ_PULSE` on the next cycle.

Top module: `uart_irq_gen`

## Requirements
- R1: While `rst_n` is low, `irq` is 0 and any pending deferred receive interrupt is discarded.
- R2: With `rx_en`=1, `rx_ie`=1 and `dly_ie`=0, a `ev_rx_char` pulse drives `irq` high in the following cycle.
- R3: With `rx_en`, `rx_ie` and `dly_ie` all 1, a received character arms a wait of T = 4*`char_bits`+4 `bit_tick` pulses. After the cycle that samples the T-th tick, `irq` goes high exactly two cycles later, once.
- R4: A received character during the wait restarts the count at zero, and it takes priority over a tick in the same cycle.
- R5: If `rx_ie` or `rx_en` is 0 in any cycle of the wait, the pending deferred interrupt is dropped and no pulse follows.
- R6: With `rx_ie`=0, received characters never produce an interrupt, whatever the value of `dly_ie`.
- R7: With `tx_ie`=1, each `ev_tx_char` pulse drives `irq` high in the next cycle.
- R8: With `sh_ie`=1, each `ev_sh_empty` pulse (shift register went from busy to empty) drives `irq` high in the next cycle.
- R9: With `brk_ie`=1, each `ev_brk` pulse drives `irq` high in the next cycle.
- R10: `ev_rxf_lvl` and `ev_txf_lvl` raise `irq` in the next cycle only when `rxf_ie` or `txf_ie`, respectively, is 1. Each is gated only by its own enable.
- R11: Any number of qualified sources active in the same cycle produce a single one-cycle-high `irq`. With no qualified source, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enabled |
| rx_ie | input | 1 | Receive interrupt enable |
| dly_ie | input | 1 | Defer the receive interrupt until the line is idle |
| tx_ie | input | 1 | Transmit interrupt enable |
| sh_ie | input | 1 | Shift-register-empty interrupt enable |
| brk_ie | input | 1 | Break interrupt enable |
| rxf_ie | input | 1 | Receive FIFO level interrupt enable |
| txf_ie | input | 1 | Transmit FIFO level interrupt enable |
| ev_rx_char | input | 1 | Pulse: a character was received |
| ev_tx_char | input | 1 | Pulse: a character was transmitted |
| ev_sh_empty | input | 1 | Pulse: the shift register went from busy to empty |
| ev_brk | input | 1 | Pulse: a break was detected |
| ev_rxf_lvl | input | 1 | Pulse: receive FIFO level condition |
| ev_txf_lvl | input | 1 | Pulse: transmit FIFO level condition |
| bit_tick | input | 1 | One pulse per bit time |
| char_bits | input | CLEN_W | Bits per character, used for the wait length |
| irq | output | 1 | Interrupt pulse |

## Verification
The deferral state is hidden from the ports, so a fault there shows only as a shifted, missing or extra deferred pulse. A counter that is off by one moves the pulse by one cycle. A reload or cancel that is missed produces a pulse where none is expected, up to T ticks after the event. A fault in source gating or merging shows one cycle after the offending event, as a missing pulse, a spurious pulse or a pulse longer than one cycle. The bench compares `irq` with a reference model on every cycle, so each fault is reported in the cycle where it first appears.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Deferred receive-interrupt sequencer
    typedef enum logic [1:0] {
        DLY_IDLE = 2'd0,
        DLY_WAIT = 2'd1,
        DLY_FIRE = 2'd2
    } dly_state_t;

    // Output pulse stage
    typedef enum logic {
        IRQ_QUIET = 1'b0,
        IRQ_PULSE = 1'b1
    } irq_state_t;

    // Source slots in the merge vector
    localparam int SRC_RX_NOW = 0;
    localparam int SRC_TX     = 1;
    localparam int SRC_SH     = 2;
    localparam int SRC_BRK    = 3;
    localparam int SRC_RXF    = 4;
    localparam int SRC_TXF    = 5;
    localparam int SRC_DLY    = 6;
    localparam int NSRC       = 7;

endpackage

// File: rtl/uart_irq_dly.sv
module uart_irq_dly
    import uart_irq_pkg::*;
#(
    parameter int CLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_ok,
    input  logic              dly_on,
    input  logic              rx_char,
    input  logic              bit_tick,
    input  logic [CLEN_W-1:0] char_bits,
    output logic              fire
);

    // Wide enough for 4*(2^CLEN_W-1)+4
    localparam int CNT_W = CLEN_W + 3;

    dly_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_tick;
    logic             start;

    // Terminal count minus one: 4*bits + 3
    assign last_tick = CNT_W'({1'b0, char_bits, 2'b00}) + CNT_W'(3);
    assign start     = rx_char && arm_ok && dly_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DLY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DLY_IDLE, DLY_FIRE: begin
                if (start) begin
                    state_d = DLY_WAIT;
                    cnt_d   = '0;
                end else begin
                    state_d = DLY_IDLE;
                end
            end
            DLY_WAIT: begin
                if (!arm_ok) begin
                    state_d = DLY_IDLE;
                end else if (rx_char) begin
                    cnt_d = '0;
                end else if (bit_tick) begin
                    if (cnt_q == last_tick) begin
                        state_d = DLY_FIRE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = DLY_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        fire = (state_q == DLY_FIRE);
    end

endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate #(
    parameter int N = 7
) (
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    output logic [N-1:0] hit
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign hit[i] = ev[i] & en[i];
    end

endmodule

// File: rtl/uart_irq_merge.sv
module uart_irq_merge
    import uart_irq_pkg::*;
#(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    output logic         irq
);

    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_QUIET: state_d = (|hit) ? IRQ_PULSE : IRQ_QUIET;
            IRQ_PULSE: state_d = (|hit) ? IRQ_PULSE : IRQ_QUIET;
            default:   state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PULSE);
    end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_irq_pkg::*;
#(
    parameter int CLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_ie,
    input  logic              dly_ie,
    input  logic              tx_ie,
    input  logic              sh_ie,
    input  logic              brk_ie,
    input  logic              rxf_ie,
    input  logic              txf_ie,
    input  logic              ev_rx_char,
    input  logic              ev_tx_char,
    input  logic              ev_sh_empty,
    input  logic              ev_brk,
    input  logic              ev_rxf_lvl,
    input  logic              ev_txf_lvl,
    input  logic              bit_tick,
    input  logic [CLEN_W-1:0] char_bits,
    output logic              irq
);

    logic            dly_fire;
    logic            rx_arm_ok;
    logic [NSRC-1:0] src_ev;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] src_hit;

    assign rx_arm_ok = rx_en && rx_ie;

    uart_irq_dly #(.CLEN_W(CLEN_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_ok    (rx_arm_ok),
        .dly_on    (dly_ie),
        .rx_char   (ev_rx_char),
        .bit_tick  (bit_tick),
        .char_bits (char_bits),
        .fire      (dly_fire)
    );

    always_comb begin
        src_ev             = '0;
        src_en             = '0;
        src_ev[SRC_RX_NOW] = ev_rx_char && rx_en;
        src_en[SRC_RX_NOW] = rx_ie && !dly_ie;
        src_ev[SRC_TX]     = ev_tx_char;
        src_en[SRC_TX]     = tx_ie;
        src_ev[SRC_SH]     = ev_sh_empty;
        src_en[SRC_SH]     = sh_ie;
        src_ev[SRC_BRK]    = ev_brk;
        src_en[SRC_BRK]    = brk_ie;
        src_ev[SRC_RXF]    = ev_rxf_lvl;
        src_en[SRC_RXF]    = rxf_ie;
        src_ev[SRC_TXF]    = ev_txf_lvl;
        src_en[SRC_TXF]    = txf_ie;
        src_ev[SRC_DLY]    = dly_fire;
        src_en[SRC_DLY]    = 1'b1;
    end

    uart_irq_gate #(.N(NSRC)) u_gate (
        .ev  (src_ev),
        .en  (src_en),
        .hit (src_hit)
    );

    uart_irq_merge #(.N(NSRC)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (src_hit),
        .irq   (irq)
    );

endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic rx_ie,
    input logic dly_ie,
    input logic tx_ie,
    input logic sh_ie,
    input logic brk_ie,
    input logic rxf_ie,
    input logic txf_ie,
    input logic ev_rx_char,
    input logic ev_tx_char,
    input logic ev_sh_empty,
    input logic ev_brk,
    input logic ev_rxf_lvl,
    input logic ev_txf_lvl,
    input logic dly_fire,
    input logic irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq);

    // R2
    rx_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_char && rx_en && rx_ie && !dly_ie) |=> irq);

    // R3
    dly_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_fire |=> irq);

    // R7
    tx_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_char && tx_ie) |=> irq);

    // R8
    sh_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sh_empty && sh_ie) |=> irq);

    // R9
    brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_brk && brk_ie) |=> irq);

    // R10
    fifo_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_rxf_lvl && rxf_ie) || (ev_txf_lvl && txf_ie)) |=> irq);

endmodule

bind uart_irq_gen uart_irq_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rx_ie       (rx_ie),
    .dly_ie      (dly_ie),
    .tx_ie       (tx_ie),
    .sh_ie       (sh_ie),
    .brk_ie      (brk_ie),
    .rxf_ie      (rxf_ie),
    .txf_ie      (txf_ie),
    .ev_rx_char  (ev_rx_char),
    .ev_tx_char  (ev_tx_char),
    .ev_sh_empty (ev_sh_empty),
    .ev_brk      (ev_brk),
    .ev_rxf_lvl  (ev_rxf_lvl),
    .ev_txf_lvl  (ev_txf_lvl),
    .dly_fire    (dly_fire),
    .irq         (irq)
);

// File: tb/uart_irq_gen_test.sv
`timescale 1ns/1ps
module uart_irq_gen_test;

    localparam int CLEN_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, rx_ie = 1'b0, dly_ie = 1'b0, tx_ie = 1'b0;
    logic sh_ie = 1'b0, brk_ie = 1'b0, rxf_ie = 1'b0, txf_ie = 1'b0;
    logic ev_rx_char = 1'b0, ev_tx_char = 1'b0, ev_sh_empty = 1'b0;
    logic ev_brk = 1'b0, ev_rxf_lvl = 1'b0, ev_txf_lvl = 1'b0;
    logic bit_tick = 1'b0;
    logic [CLEN_W-1:0] char_bits = 4'd2;
    logic irq;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    bit m_wait = 1'b0;
    bit m_pend = 1'b0;
    int m_left = 0;

    always #5 clk = ~clk;

    uart_irq_gen #(.CLEN_W(CLEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_en(rx_en), .rx_ie(rx_ie), .dly_ie(dly_ie), .tx_ie(tx_ie),
        .sh_ie(sh_ie), .brk_ie(brk_ie), .rxf_ie(rxf_ie), .txf_ie(txf_ie),
        .ev_rx_char(ev_rx_char), .ev_tx_char(ev_tx_char),
        .ev_sh_empty(ev_sh_empty), .ev_brk(ev_brk),
        .ev_rxf_lvl(ev_rxf_lvl), .ev_txf_lvl(ev_txf_lvl),
        .bit_tick(bit_tick), .char_bits(char_bits), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wait_len(input int bits);
        return 4 * bits + 4;
    endfunction

    // Expected irq after the coming edge, given the inputs now applied
    function automatic bit immediate_src();
        return (ev_tx_char && tx_ie) || (ev_sh_empty && sh_ie) ||
               (ev_brk && brk_ie) || (ev_rxf_lvl && rxf_ie) ||
               (ev_txf_lvl && txf_ie) ||
               (ev_rx_char && rx_en && rx_ie && !dly_ie);
    endfunction

    // One clock: model step, edge, compare at the falling edge
    task automatic cycle();
        bit exp;
        bit nxt;
        exp = immediate_src() || m_pend;
        nxt = 1'b0;
        if (m_wait) begin
            if (!rx_ie || !rx_en) m_wait = 1'b0;
            else if (ev_rx_char) m_left = wait_len(int'(char_bits));
            else if (bit_tick) begin
                if (m_left == 1) begin
                    m_wait = 1'b0;
                    nxt = 1'b1;
                end else m_left--;
            end
        end else if (ev_rx_char && rx_en && rx_ie && dly_ie) begin
            m_wait = 1'b1;
            m_left = wait_len(int'(char_bits));
        end
        m_pend = nxt;
        @(negedge clk);
        if (irq) pulses++;
        check(irq === exp, cur_tag, int'(irq), int'(exp));
    endtask

    task automatic clear_events();
        ev_rx_char = 0; ev_tx_char = 0; ev_sh_empty = 0;
        ev_brk = 0; ev_rxf_lvl = 0; ev_txf_lvl = 0; bit_tick = 0;
    endtask

    task automatic idle(input int n);
        clear_events();
        for (int i = 0; i < n; i++) cycle();
    endtask

    // Send one received character, then n ticks on consecutive cycles
    task automatic rx_then_ticks(input int n);
        clear_events();
        ev_rx_char = 1;
        cycle();
        ev_rx_char = 0;
        bit_tick = 1;
        for (int i = 0; i < n; i++) cycle();
        bit_tick = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: events and enables active during reset
        rx_en = 1; rx_ie = 1; tx_ie = 1; ev_tx_char = 1; ev_rx_char = 1;
        repeat (3) @(negedge clk);
        check(irq === 1'b0, "R1", int'(irq), 0);
        clear_events();
        rst_n = 1;
        rx_en = 0; rx_ie = 0; tx_ie = 0;
        cur_tag = "R1";
        idle(3);

        // R2: immediate receive interrupt
        cur_tag = "R2";
        rx_en = 1; rx_ie = 1; dly_ie = 0;
        pulses = 0;
        rx_then_ticks(0);
        idle(3);
        check(pulses == 1, "R2", pulses, 1);

        // R6: receive interrupt disabled, both modes
        cur_tag = "R6";
        rx_ie = 0;
        pulses = 0;
        dly_ie = 0; rx_then_ticks(15);
        dly_ie = 1; rx_then_ticks(15);
        idle(3);
        check(pulses == 0, "R6", pulses, 0);

        // R3: deferred pulse after 4*bits+4 ticks (bits=2 -> 12)
        cur_tag = "R3";
        rx_ie = 1; dly_ie = 1; char_bits = 4'd2;
        pulses = 0;
        rx_then_ticks(11);
        check(pulses == 0, "R3", pulses, 0);
        bit_tick = 1; cycle(); bit_tick = 0;
        cycle();
        check(irq === 1'b1, "R3", int'(irq), 1);
        idle(5);
        check(pulses == 1, "R3", pulses, 1);

        // R4: reload on a character that coincides with a tick
        cur_tag = "R4";
        pulses = 0;
        rx_then_ticks(10);
        ev_rx_char = 1; bit_tick = 1; cycle(); ev_rx_char = 0;
        for (int i = 0; i < 11; i++) cycle();
        bit_tick = 0; idle(2);
        check(pulses == 0, "R4", pulses, 0);
        bit_tick = 1; cycle(); bit_tick = 0; idle(3);
        check(pulses == 1, "R4", pulses, 1);

        // R5: cancel by rx_ie, then by rx_en
        cur_tag = "R5";
        pulses = 0;
        rx_then_ticks(5);
        rx_ie = 0; idle(1); rx_ie = 1;
        bit_tick = 1; for (int i = 0; i < 20; i++) cycle();
        rx_then_ticks(5);
        rx_en = 0; idle(1); rx_en = 1;
        bit_tick = 1; for (int i = 0; i < 20; i++) cycle();
        idle(2);
        check(pulses == 0, "R5", pulses, 0);

        // R7, R8, R9, R10: each source alone, enabled and not
        cur_tag = "R7";
        pulses = 0; tx_ie = 1; ev_tx_char = 1; cycle(); idle(2);
        tx_ie = 0; ev_tx_char = 1; cycle(); idle(2);
        check(pulses == 1, "R7", pulses, 1);
        cur_tag = "R8";
        pulses = 0; sh_ie = 1; ev_sh_empty = 1; cycle(); idle(2);
        sh_ie = 0; ev_sh_empty = 1; cycle(); idle(2);
        check(pulses == 1, "R8", pulses, 1);
        cur_tag = "R9";
        pulses = 0; brk_ie = 1; ev_brk = 1; cycle(); idle(2);
        brk_ie = 0; ev_brk = 1; cycle(); idle(2);
        check(pulses == 1, "R9", pulses, 1);
        cur_tag = "R10";
        pulses = 0;
        rxf_ie = 1; txf_ie = 0; ev_txf_lvl = 1; cycle(); idle(2);
        ev_rxf_lvl = 1; cycle(); idle(2);
        rxf_ie = 0; txf_ie = 1; ev_rxf_lvl = 1; cycle(); idle(2);
        ev_txf_lvl = 1; cycle(); idle(2);
        check(pulses == 2, "R10", pulses, 2);

        // R11: all sources together give one pulse
        cur_tag = "R11";
        pulses = 0;
        dly_ie = 0; tx_ie = 1; sh_ie = 1; brk_ie = 1; rxf_ie = 1; txf_ie = 1;
        ev_rx_char = 1; ev_tx_char = 1; ev_sh_empty = 1;
        ev_brk = 1; ev_rxf_lvl = 1; ev_txf_lvl = 1;
        cycle();
        idle(3);
        check(pulses == 1, "R11", pulses, 1);

        // Random phases, per-cycle comparison with the model
        for (int ph = 0; ph < 4; ph++) begin
            cur_tag = "R11";
            rx_ie = 0; idle(4 * 40);
            char_bits = CLEN_W'(ph + 1);
            for (int c = 0; c < 4000; c++) begin
                if ($urandom_range(0, 63) == 0) rx_ie = $urandom_range(0, 7) != 0;
                if ($urandom_range(0, 63) == 0) rx_en = $urandom_range(0, 7) != 0;
                if ($urandom_range(0, 127) == 0) dly_ie = $urandom_range(0, 1);
                if ($urandom_range(0, 63) == 0) begin
                    tx_ie = $urandom_range(0, 1); sh_ie = $urandom_range(0, 1);
                    brk_ie = $urandom_range(0, 1); rxf_ie = $urandom_range(0, 1);
                    txf_ie = $urandom_range(0, 1);
                end
                ev_rx_char  = $urandom_range(0, 39) == 0;
                ev_tx_char  = $urandom_range(0, 49) == 0;
                ev_sh_empty = $urandom_range(0, 59) == 0;
                ev_brk      = $urandom_range(0, 199) == 0;
                ev_rxf_lvl  = $urandom_range(0, 79) == 0;
                ev_txf_lvl  = $urandom_range(0, 79) == 0;
                bit_tick    = $urandom_range(0, 1);
                cycle();
            end
            clear_events();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule